// File: doc/BRIEF.md
# Compare and Test Flag Generator

This block evaluates two condition-setting operations on a pair of operands and returns only the six status flags: sign, zero, parity, carry, overflow and auxiliary carry. The first operation is a bitwise-AND test, which shows which bits the two operands have in common. The second is a compare, which subtracts the second operand from the first. In both cases the arithmetic result is discarded. Downstream branch logic uses the flags to decide whether a conditional transfer is taken.

The operand size can be 8, 16 or 32 bits. Any operand bits above the selected width have no effect. A narrow-immediate input marks the second operand as an 8-bit immediate. Its low byte is then sign-extended to the operand width before use. All six flags are registered, so each result appears one clock after its inputs are presented.

Top module: `cfu_flag_unit`

## Requirements
- R1: The flags are registered. A set of inputs presented before a rising clock edge produces its flags after that edge. While `rst_n` is low, all six flags read 0.
- R2: When `op_sel`=0 (test), `flag_sign` equals the most significant bit of (A AND B) at the selected width. `flag_zero` is 1 exactly when that AND result is zero.
- R3: For a test, `flag_carry`, `flag_overflow` and `flag_aux` are always 0.
- R4: `flag_parity` is 1 when bits 7..0 of the operation result contain an even number of ones, at every operand size.
- R5: When `op_sel`=1 (compare), `flag_sign` is the most significant bit of A−B at the selected width. `flag_zero` is 1 exactly when that difference is zero.
- R6: For a compare, `flag_carry` is 1 exactly when A < B as unsigned numbers at the selected width.
- R7: For a compare, `flag_overflow` is 1 exactly when A and B have different sign bits and the sign bit of the difference differs from A's sign bit.
- R8: For a compare, `flag_aux` is 1 exactly when bits 3..0 of A, read as unsigned, are less than bits 3..0 of B. This is a borrow out of bit 3 into bit 4.
- R9: When `imm_narrow`=1, bits 7..0 of B are sign-extended to the operand width and used in place of B, for both operations.
- R10: `size_sel` encodes 0 as 8 bits, 1 as 16 bits, 2 as 32 bits, and 3 also as 32 bits. Operand bits above the selected width do not change any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_sel | input | 1 | 0 = AND test, 1 = compare (A−B) |
| size_sel | input | 2 | Operand width: 0=8, 1=16, 2 or 3=32 |
| opnd_a | input | 32 | First operand (minuend for compare) |
| opnd_b | input | 32 | Second operand (subtrahend for compare) |
| imm_narrow | input | 1 | Sign-extend B[7:0] to the operand width |
| flag_sign | output | 1 | Sign flag |
| flag_zero | output | 1 | Zero flag |
| flag_parity | output | 1 | Even parity of result bits 7..0 |
| flag_carry | output | 1 | Unsigned borrow (compare only) |
| flag_overflow | output | 1 | Signed overflow (compare only) |
| flag_aux | output | 1 | Borrow out of bit 3 (compare only) |

## Verification
The bench uses the default package values: a 32-bit datapath, an 8-bit immediate and an 8-bit parity window. Under these values the three width lanes cover every size encoding, including the spare code 3. Sign extension of the immediate can therefore be observed crossing into both the 16-bit and the 32-bit lanes. Directed vectors place the signed and unsigned boundaries in each lane: the most negative minus one, zero minus one, and equal operands. They also drive junk above the selected width. Seeded random vectors spread the remaining cases across both operations and every size.

// File: rtl/cfu_pkg.sv
package cfu_pkg;
    localparam int DATA_W = 32;
    localparam int IMM_W  = 8;
    localparam int PAR_W  = 8;
    localparam int NIB_W  = 4;
    localparam int LANES  = 3;
    localparam int BASE_W = 8;

    typedef enum logic {
        OP_TEST = 1'b0,
        OP_CMP  = 1'b1
    } cfu_op_e;

    typedef enum logic [1:0] {
        SZ_8   = 2'd0,
        SZ_16  = 2'd1,
        SZ_32  = 2'd2,
        SZ_32X = 2'd3
    } cfu_size_e;

    typedef struct packed {
        logic af;
        logic cf;
        logic of;
        logic pf;
        logic sf;
        logic zf;
    } cfu_flags_t;
endpackage

// File: rtl/cfu_operand_shaper.sv
module cfu_operand_shaper
    import cfu_pkg::*;
#(
    parameter int W   = DATA_W,
    parameter int IW  = IMM_W,
    parameter int NL  = LANES,
    parameter int BW  = BASE_W
) (
    input  logic [1:0]   size_sel,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         imm_narrow,
    output logic [W-1:0] a_m,
    output logic [W-1:0] b_m,
    output logic [W-1:0] width_mask,
    output logic [W-1:0] msb_mask
);
    localparam int LW = (NL > 1) ? $clog2(NL) : 1;

    logic [W-1:0] lane_mask [NL];
    logic [LW-1:0] lane_idx;
    logic [W-1:0] b_sx;

    // one mask per supported width, each lane twice the width of the previous
    for (genvar i = 0; i < NL; i++) begin : g_lane
        localparam int LANE_W = BW << i;
        assign lane_mask[i] = {W{1'b1}} >> (W - LANE_W);
    end

    always_comb begin
        if (int'(size_sel) >= NL) lane_idx = LW'(NL - 1);
        else                      lane_idx = LW'(size_sel);
    end

    assign width_mask = lane_mask[lane_idx];
    assign msb_mask   = width_mask ^ (width_mask >> 1);

    assign b_sx = imm_narrow ? {{(W-IW){b_in[IW-1]}}, b_in[IW-1:0]} : b_in;

    assign a_m = a_in & width_mask;
    assign b_m = b_sx & width_mask;
endmodule

// File: rtl/cfu_parity.sv
module cfu_parity #(
    parameter int PW = 8
) (
    input  logic [PW-1:0] bits_in,
    output logic          even_out
);
    localparam int LVL = (PW > 1) ? $clog2(PW) : 1;
    localparam int PAD = 1 << LVL;

    logic [PAD-1:0] stage [LVL+1];

    assign stage[0] = PAD'(bits_in);

    // balanced XOR reduction, one level per halving
    for (genvar l = 0; l < LVL; l++) begin : g_lvl
        localparam int N = PAD >> (l + 1);
        for (genvar k = 0; k < N; k++) begin : g_node
            assign stage[l+1][k] = stage[l][2*k] ^ stage[l][2*k+1];
        end
        if (N < PAD) begin : g_fill
            assign stage[l+1][PAD-1:N] = '0;
        end
    end

    assign even_out = ~stage[LVL][0];
endmodule

// File: rtl/cfu_arith.sv
module cfu_arith
    import cfu_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int NW = NIB_W
) (
    input  logic         is_cmp,
    input  logic [W-1:0] a_m,
    input  logic [W-1:0] b_m,
    input  logic [W-1:0] width_mask,
    input  logic [W-1:0] msb_mask,
    output logic [W-1:0] result,
    output logic         res_msb,
    output logic         borrow,
    output logic         ovf,
    output logic         nib_borrow
);
    logic [W:0]   diff_ext;
    logic [W-1:0] and_v;
    logic         a_msb;
    logic         b_msb;

    assign diff_ext = {1'b0, a_m} - {1'b0, b_m};
    assign and_v    = a_m & b_m;

    always_comb begin
        result  = (is_cmp ? diff_ext[W-1:0] : and_v) & width_mask;
        res_msb = |(result & msb_mask);
        a_msb   = |(a_m & msb_mask);
        b_msb   = |(b_m & msb_mask);
        // masked operands make every narrower borrow ripple to the top bit
        borrow     = is_cmp & diff_ext[W];
        ovf        = is_cmp & (a_msb ^ b_msb) & (res_msb ^ a_msb);
        nib_borrow = is_cmp & (a_m[NW] ^ b_m[NW] ^ diff_ext[NW]);
    end
endmodule

// File: rtl/cfu_flag_unit.sv
module cfu_flag_unit
    import cfu_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        op_sel,
    input  logic [1:0]  size_sel,
    input  logic [31:0] opnd_a,
    input  logic [31:0] opnd_b,
    input  logic        imm_narrow,
    output logic        flag_sign,
    output logic        flag_zero,
    output logic        flag_parity,
    output logic        flag_carry,
    output logic        flag_overflow,
    output logic        flag_aux
);
    logic [DATA_W-1:0] a_m, b_m, width_mask, msb_mask, result;
    logic res_msb, borrow, ovf, nib_borrow, par_even;
    logic is_cmp;
    cfu_flags_t flags_d, flags_q;

    assign is_cmp = (cfu_op_e'(op_sel) == OP_CMP);

    cfu_operand_shaper u_shape (
        .size_sel   (size_sel),
        .a_in       (opnd_a),
        .b_in       (opnd_b),
        .imm_narrow (imm_narrow),
        .a_m        (a_m),
        .b_m        (b_m),
        .width_mask (width_mask),
        .msb_mask   (msb_mask)
    );

    cfu_arith u_arith (
        .is_cmp     (is_cmp),
        .a_m        (a_m),
        .b_m        (b_m),
        .width_mask (width_mask),
        .msb_mask   (msb_mask),
        .result     (result),
        .res_msb    (res_msb),
        .borrow     (borrow),
        .ovf        (ovf),
        .nib_borrow (nib_borrow)
    );

    cfu_parity #(.PW(PAR_W)) u_par (
        .bits_in  (result[PAR_W-1:0]),
        .even_out (par_even)
    );

    always_comb begin
        flags_d    = '0;
        flags_d.sf = res_msb;
        flags_d.zf = (result == '0);
        flags_d.pf = par_even;
        flags_d.cf = borrow;
        flags_d.of = ovf;
        flags_d.af = nib_borrow;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flag_sign     = flags_q.sf;
    assign flag_zero     = flags_q.zf;
    assign flag_parity   = flags_q.pf;
    assign flag_carry    = flags_q.cf;
    assign flag_overflow = flags_q.of;
    assign flag_aux      = flags_q.af;

    AST_TEST_NO_CO: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(op_sel)) |-> (!flag_carry && !flag_overflow)); // R3
    AST_TEST_NO_AF: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(op_sel)) |-> !flag_aux); // R3
    AST_ZERO_HAS_NO_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        flag_zero |-> !flag_sign); // R5
    AST_CMP_SELF_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_sel) && !$past(imm_narrow) && ($past(opnd_a) == $past(opnd_b)))
        |-> (flag_zero && !flag_carry && !flag_overflow && !flag_aux && flag_parity)); // R6
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !$past(rst_n) |-> (flags_q == '0)); // R1
endmodule

// File: tb/tb_cfu_flag_unit.sv
`timescale 1ns/1ps
module tb_cfu_flag_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_sel = 1'b0;
    logic [1:0]  size_sel = 2'd0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic        imm_narrow = 1'b0;
    logic        flag_sign, flag_zero, flag_parity, flag_carry, flag_overflow, flag_aux;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cfu_flag_unit dut (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .size_sel(size_sel),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .imm_narrow(imm_narrow),
        .flag_sign(flag_sign), .flag_zero(flag_zero), .flag_parity(flag_parity),
        .flag_carry(flag_carry), .flag_overflow(flag_overflow), .flag_aux(flag_aux)
    );

    // returns {af, cf, of, pf, sf, zf}
    function automatic logic [5:0] model(input logic op, input logic [1:0] sz,
                                         input logic [31:0] a, input logic [31:0] b,
                                         input logic imm);
        int w;
        logic [31:0] mask, am, bm, bx, r;
        longint sa, sb, t, lim;
        logic cf, of, af;
        w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        mask = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
        bx = imm ? {{24{b[7]}}, b[7:0]} : b;
        am = a & mask;
        bm = bx & mask;
        if (!op) begin
            r = am & bm;
            return {3'b000, ~^r[7:0], r[w-1], r == 32'h0};
        end
        r = (am - bm) & mask;
        cf = am < bm;
        sa = longint'(am);
        if (am[w-1]) sa = sa - (longint'(1) << w);
        sb = longint'(bm);
        if (bm[w-1]) sb = sb - (longint'(1) << w);
        t = sa - sb;
        lim = longint'(1) << (w - 1);
        of = (t >= lim) || (t < -lim);
        af = am[3:0] < bm[3:0];
        return {af, cf, of, ~^r[7:0], r[w-1], r == 32'h0};
    endfunction

    function automatic logic [5:0] got();
        return {flag_aux, flag_carry, flag_overflow, flag_parity, flag_sign, flag_zero};
    endfunction

    task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: flags{af,cf,of,pf,sf,zf} actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic apply(input string tag, input logic op, input logic [1:0] sz,
                         input logic [31:0] a, input logic [31:0] b, input logic imm);
        @(negedge clk);
        op_sel = op; size_sel = sz; opnd_a = a; opnd_b = b; imm_narrow = imm;
        @(negedge clk);
        check(tag, got(), model(op, sz, a, b, imm));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state with non-trivial inputs held
        op_sel = 1'b1; opnd_a = 32'h0; opnd_b = 32'h1; size_sel = 2'd2;
        repeat (3) @(negedge clk);
        check("R1 reset", got(), 6'b000000);
        rst_n = 1'b1;
        // R1: one-cycle latency, value then changes on next edge
        @(negedge clk);
        check("R1 latency", got(), model(1'b1, 2'd2, 32'h0, 32'h1, 1'b0));

        apply("R2 test disjoint", 1'b0, 2'd2, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 1'b0);
        apply("R2 test sign16", 1'b0, 2'd1, 32'h0000_8001, 32'h0000_8000, 1'b0);
        apply("R3 test all ones", 1'b0, 2'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
        apply("R4 parity odd low byte", 1'b0, 2'd2, 32'hFF00_0007, 32'hFF00_00FF, 1'b0);
        apply("R4 parity cmp", 1'b1, 2'd1, 32'h0000_0103, 32'h0000_0000, 1'b0);
        apply("R5 cmp equal", 1'b1, 2'd0, 32'h0000_0055, 32'h0000_0055, 1'b0);
        apply("R6 zero minus one 32", 1'b1, 2'd2, 32'h0, 32'h1, 1'b0);
        apply("R6 zero minus one 8", 1'b1, 2'd0, 32'h0, 32'h1, 1'b0);
        apply("R7 min8 minus one", 1'b1, 2'd0, 32'h80, 32'h01, 1'b0);
        apply("R7 max16 minus neg", 1'b1, 2'd1, 32'h7FFF, 32'hFFFF, 1'b0);
        apply("R7 min32 minus one", 1'b1, 2'd2, 32'h8000_0000, 32'h1, 1'b0);
        apply("R8 nibble borrow", 1'b1, 2'd2, 32'h0000_0010, 32'h0000_0001, 1'b0);
        apply("R8 no nibble borrow", 1'b1, 2'd2, 32'h0000_001F, 32'h0000_0011, 1'b0);
        apply("R9 imm minus one 32", 1'b1, 2'd2, 32'hFFFF_FFFF, 32'h1234_56FF, 1'b1);
        apply("R9 imm negative 16", 1'b1, 2'd1, 32'h0000_0000, 32'h0000_0080, 1'b1);
        apply("R9 imm test 16", 1'b0, 2'd1, 32'h0000_8000, 32'h0000_00F0, 1'b1);
        apply("R10 junk above 8", 1'b1, 2'd0, 32'hABCD_EF10, 32'h1234_5610, 1'b0);
        apply("R10 junk above 16", 1'b0, 2'd1, 32'hFFFF_0000, 32'hFFFF_1234, 1'b0);
        apply("R10 size code 3", 1'b1, 2'd3, 32'h8000_0000, 32'h0000_0001, 1'b0);

        for (int i = 0; i < 400; i++) begin
            logic op;
            logic [31:0] a, b;
            op = 1'($urandom);
            a = $urandom;
            b = $urandom;
            if (($urandom % 8) == 0) b = a;
            apply(op ? "R5 random cmp" : "R2 random test", op, 2'($urandom),
                  a, b, (($urandom % 4) == 0));
        end

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule